// File: doc/BRIEF.md
# Per-Port Source Address Security Filter

This block sits beside a multi-port repeater and decides, frame by frame, whether the station sending on a port is allowed on it. It watches the received byte stream, collects the 48-bit source address that follows the 6-byte destination field, and compares it against a small address store. Each port owns one private entry. A pool of shared entries can also be used by any set of ports, chosen by a per-entry port mask. When a secured port carries a source address that matches nothing it may use, the block raises `scramble` on the clock after the last source byte. The repeater datapath then sends `rand_bit`, a pseudo-random stream, in place of the rest of the frame, on the local ports and the expansion path alike.

Software loads the store through a byte-wide register port. An address is written one byte at a time, six writes per entry, and a per-entry loaded field records which bytes are present. Shared entries also carry a valid bit and a port mask. Security is switched on for all ports at once with a global bit, or for single ports. A port in learn mode writes the source address of its next frames into its private entry and lets those frames pass.

The frame controller has five states. `S_IDLE` waits for `rx_active` and latches the port number. `S_DEST` counts the six destination bytes. `S_SRC` gathers the source bytes and makes the decision on the sixth one, moving to `S_PASS` on a hit, an unsecured port or learn mode, and to `S_BLOCK` otherwise. Every state returns to `S_IDLE` when `rx_active` falls.

Top module: `sag_guard`

## Requirements
- R1: After reset `scramble` and `rand_bit` are 0. Every loaded field, valid bit, port mask, port control and the global enable read as 0.
- R2: The register address is `{kind[2:0], index}`. A write of kind 0 (private entry of port `index`) or kind 1 (shared entry `index`) stores the byte in the lowest unloaded position and sets that position's bit in the entry's loaded field. Position i holds address bits [8i+7:8i], and position 0 pairs with the first source byte received. A read of kind 0 or 1 returns the loaded field, which is always a run of ones from bit 0.
- R3: A byte write to an entry whose six loaded bits are all set starts the entry over. The byte goes to position 0 and the loaded field reads 0x01.
- R4: A frame is bytes 1 to 6 for the destination and bytes 7 to 12 for the source. `scramble` stays 0 until the 12th byte is taken. It rises on the clock after that byte when the port is secured, not learning, and has no hit.
- R5: Once raised, `scramble` stays 1 while `rx_active` is high. It returns to 0 on the clock after `rx_active` falls.
- R6: A private entry matches only frames received on its own port, and only when all six bytes are loaded and equal to the source address.
- R7: An entry with fewer than six loaded bytes never matches, even when its valid bit is set.
- R8: A shared entry matches a frame on port p only when its valid bit (kind 3, wdata bit 0) is 1, all six bytes are loaded, and bit p of its port mask (kind 2, wdata bits [NPORTS-1:0]) is 1.
- R9: A port is secured when the global enable (kind 7, wdata bit 0) or its own enable (kind 6, wdata bit 0) is 1. An unsecured port never scrambles.
- R10: When a port's learn bit (kind 6, wdata bit 1) is set, the 12th byte of a frame on that port writes the full source address into the port's private entry, whose loaded field then reads 0x3F. That frame is not scrambled.
- R11: `rand_bit` is 0 while `scramble` is 0. While `scramble` is 1 it equals bit 12 of a 13-bit register that resets to 1 and becomes `{s[11:0], s[12]^s[3]^s[2]^s[0]}` on each clock where both `bit_tick` and `scramble` are 1.
- R12: Reads return the port mask for kind 2, the valid bit in bit 0 for kind 3, `{learn, secure}` in bits [1:0] for kind 6 and the global enable in bit 0 for kind 7. Kinds 4 and 5 and out-of-range indices read 0 and have no effect when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3+IW | Register kind and index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| rx_active | input | 1 | High for the length of a received frame |
| rx_port | input | PW | Receiving port, held during the frame |
| rx_byte_valid | input | 1 | `rx_byte` carries a new frame byte |
| rx_byte | input | 8 | Received frame byte |
| bit_tick | input | 1 | One pulse per bit time |
| scramble | output | 1 | Replace the frame with random data |
| rand_bit | output | 1 | Pseudo-random substitute bit |

## Verification
The bench sweeps every port against every value of a shared entry's port mask. A design that indexes the mask by the wrong port, or ignores it, blocks or passes the wrong combinations. Entries loaded to five bytes, and entries that wrap back to one byte, are fed their matching address; a design that compares before the loaded field is full would let those frames through. The bench checks `scramble` just before and just after the 12th byte, and again when `rx_active` drops, so a decision made a byte early or a release made a clock late shows up. The learn path and the substitute bit stream are compared against a model built from the stated polynomial and seed.

// File: rtl/sag_pkg.sv
package sag_pkg;
    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = 8 * MAC_BYTES;
    localparam int LFSR_W    = 13;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEST,
        S_SRC,
        S_PASS,
        S_BLOCK
    } frame_state_t;

    typedef enum logic [2:0] {
        K_PRIV   = 3'd0,
        K_SHARED = 3'd1,
        K_MASK   = 3'd2,
        K_VALID  = 3'd3,
        K_RSV4   = 3'd4,
        K_RSV5   = 3'd5,
        K_PCTRL  = 3'd6,
        K_GLOBAL = 3'd7
    } reg_kind_t;
endpackage

// File: rtl/sag_entry.sv
module sag_entry
    import sag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_byte,
    input  logic [7:0]           wdata,
    input  logic                 learn_load,
    input  logic [MAC_W-1:0]     learn_addr,
    input  logic [MAC_W-1:0]     cmp_addr,
    output logic                 hit,
    output logic [MAC_BYTES-1:0] loaded
);
    localparam logic [MAC_BYTES-1:0] ALL_SET = '1;

    logic [MAC_W-1:0] addr_q;
    logic [2:0]       slot;

    always_comb slot = 3'($countones(loaded));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            loaded <= '0;
        end else if (learn_load) begin
            addr_q <= learn_addr;
            loaded <= ALL_SET;
        end else if (wr_byte) begin
            if (loaded == ALL_SET) begin
                addr_q[7:0] <= wdata;
                loaded      <= MAC_BYTES'(1);
            end else begin
                addr_q[int'(slot)*8 +: 8] <= wdata;
                loaded[slot]              <= 1'b1;
            end
        end
    end

    always_comb hit = (loaded == ALL_SET) && (addr_q == cmp_addr);

    // R2: loaded bytes always form a run from position 0
    p_loaded_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded & (loaded + 1'b1)) == '0);

    // R3: a write to a full entry starts it over
    p_wrap_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte && !learn_load && loaded == ALL_SET) |=> (loaded == MAC_BYTES'(1)));

    // R10: a learned address leaves the entry complete
    p_learn_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        learn_load |=> (loaded == ALL_SET));
endmodule

// File: rtl/sag_lfsr.sv
module sag_lfsr
    import sag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic out_bit
);
    logic [LFSR_W-1:0] s_q;
    logic              fb;

    always_comb fb = s_q[12] ^ s_q[3] ^ s_q[2] ^ s_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    s_q <= LFSR_W'(1);
        else if (step) s_q <= {s_q[LFSR_W-2:0], fb};
    end

    always_comb out_bit = s_q[LFSR_W-1];

    // R11: the generator never falls into the all-zero lock state
    p_lfsr_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q != '0);

    // R11: the state holds between steps
    p_lfsr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(s_q));
endmodule

// File: rtl/sag_fsm.sv
module sag_fsm
    import sag_pkg::*;
#(
    parameter int PW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_active,
    input  logic [PW-1:0]    rx_port,
    input  logic             rx_byte_valid,
    input  logic [7:0]       rx_byte,
    input  logic             secured,
    input  logic             learning,
    input  logic             hit,
    output logic [PW-1:0]    cur_port,
    output logic [MAC_W-1:0] sa_cmp,
    output logic             learn_load,
    output logic             scramble
);
    localparam int CNT_W = $clog2(2 * MAC_BYTES + 1);
    localparam logic [CNT_W-1:0] DA_LAST  = CNT_W'(MAC_BYTES - 1);
    localparam logic [CNT_W-1:0] SA_FIRST = CNT_W'(MAC_BYTES);
    localparam logic [CNT_W-1:0] SA_LAST  = CNT_W'(2 * MAC_BYTES - 1);

    frame_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [MAC_W-1:0] sa_q;
    logic             byte_take, last_da, last_sa;

    always_comb begin
        byte_take = rx_active && rx_byte_valid &&
                    (state_q == S_IDLE || state_q == S_DEST || state_q == S_SRC);
        last_da   = byte_take && (cnt_q == DA_LAST);
        last_sa   = byte_take && (cnt_q == SA_LAST);
        sa_cmp    = sa_q;
        sa_cmp[MAC_W-1 -: 8] = rx_byte;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (rx_active) state_d = S_DEST;
            S_DEST: begin
                if (!rx_active)   state_d = S_IDLE;
                else if (last_da) state_d = S_SRC;
            end
            S_SRC: begin
                if (!rx_active)   state_d = S_IDLE;
                else if (last_sa) state_d = (learning || !secured || hit) ? S_PASS : S_BLOCK;
            end
            S_PASS:  if (!rx_active) state_d = S_IDLE;
            S_BLOCK: if (!rx_active) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sa_q     <= '0;
            cur_port <= '0;
        end else begin
            if (!rx_active)     cnt_q <= '0;
            else if (byte_take) cnt_q <= cnt_q + 1'b1;
            if (byte_take && cnt_q >= SA_FIRST && cnt_q < SA_LAST)
                sa_q[int'(cnt_q - SA_FIRST)*8 +: 8] <= rx_byte;
            if (state_q == S_IDLE) cur_port <= rx_port;
        end
    end

    always_comb begin
        scramble   = (state_q == S_BLOCK);
        learn_load = last_sa && learning;
    end

    // R5: leaving the frame always returns to idle
    p_end_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |=> (state_q == S_IDLE));

    // R5: a blocked frame stays blocked while it lasts
    p_block_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BLOCK && rx_active) |=> (state_q == S_BLOCK));

    // R4: blocking starts only from the last source byte
    p_block_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_BLOCK) |-> ($past(state_q) == S_SRC && $past(cnt_q) == SA_LAST));

    // R10: a learning frame passes
    p_learn_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        learn_load |=> (state_q == S_PASS));
endmodule

// File: rtl/sag_guard.sv
module sag_guard
    import sag_pkg::*;
#(
    parameter int NPORTS  = 4,
    parameter int NSHARED = 32,
    localparam int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int IDX_N  = (NPORTS > NSHARED) ? NPORTS : NSHARED,
    localparam int IW     = (IDX_N > 1) ? $clog2(IDX_N) : 1,
    localparam int AW     = 3 + IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          rx_active,
    input  logic [PW-1:0] rx_port,
    input  logic          rx_byte_valid,
    input  logic [7:0]    rx_byte,
    input  logic          bit_tick,
    output logic          scramble,
    output logic          rand_bit
);
    reg_kind_t     kind;
    logic [IW-1:0] idx;

    logic [MAC_BYTES-1:0] priv_loaded [NPORTS];
    logic [MAC_BYTES-1:0] sh_loaded   [NSHARED];
    logic [NPORTS-1:0]    priv_hit;
    logic [NSHARED-1:0]   sh_hit, sh_ok, sh_valid;
    logic [NPORTS-1:0]    sh_mask     [NSHARED];
    logic [NPORTS-1:0]    port_sec, port_learn;
    logic                 glob_sec;

    logic [PW-1:0]    cur_port;
    logic [MAC_W-1:0] sa_cmp;
    logic             learn_load, secured, learning, hit, own_hit, lfsr_bit;

    always_comb begin
        kind = reg_kind_t'(reg_addr[AW-1 -: 3]);
        idx  = reg_addr[IW-1:0];
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_priv
        sag_entry u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_byte    (reg_wr && kind == K_PRIV && idx == IW'(p)),
            .wdata      (reg_wdata),
            .learn_load (learn_load && cur_port == PW'(p)),
            .learn_addr (sa_cmp),
            .cmp_addr   (sa_cmp),
            .hit        (priv_hit[p]),
            .loaded     (priv_loaded[p])
        );
    end

    for (genvar s = 0; s < NSHARED; s++) begin : g_shared
        sag_entry u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_byte    (reg_wr && kind == K_SHARED && idx == IW'(s)),
            .wdata      (reg_wdata),
            .learn_load (1'b0),
            .learn_addr ('0),
            .cmp_addr   (sa_cmp),
            .hit        (sh_hit[s]),
            .loaded     (sh_loaded[s])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_valid   <= '0;
            port_sec   <= '0;
            port_learn <= '0;
            glob_sec   <= 1'b0;
            for (int s = 0; s < NSHARED; s++) sh_mask[s] <= '0;
        end else if (reg_wr) begin
            for (int s = 0; s < NSHARED; s++) begin
                if (idx == IW'(s) && kind == K_MASK)  sh_mask[s]  <= reg_wdata[NPORTS-1:0];
                if (idx == IW'(s) && kind == K_VALID) sh_valid[s] <= reg_wdata[0];
            end
            for (int p = 0; p < NPORTS; p++) begin
                if (idx == IW'(p) && kind == K_PCTRL) begin
                    port_sec[p]   <= reg_wdata[0];
                    port_learn[p] <= reg_wdata[1];
                end
            end
            if (kind == K_GLOBAL) glob_sec <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (idx == IW'(p) && kind == K_PRIV)  reg_rdata = 8'(priv_loaded[p]);
            if (idx == IW'(p) && kind == K_PCTRL) reg_rdata = {6'b0, port_learn[p], port_sec[p]};
        end
        for (int s = 0; s < NSHARED; s++) begin
            if (idx == IW'(s) && kind == K_SHARED) reg_rdata = 8'(sh_loaded[s]);
            if (idx == IW'(s) && kind == K_MASK)   reg_rdata = 8'(sh_mask[s]);
            if (idx == IW'(s) && kind == K_VALID)  reg_rdata = {7'b0, sh_valid[s]};
        end
        if (kind == K_GLOBAL) reg_rdata = {7'b0, glob_sec};
    end

    always_comb begin
        secured  = 1'b0;
        learning = 1'b0;
        own_hit  = 1'b0;
        for (int p = 0; p < NPORTS; p++) begin
            if (cur_port == PW'(p)) begin
                secured  = glob_sec | port_sec[p];
                learning = port_learn[p];
                own_hit  = priv_hit[p];
            end
        end
        for (int s = 0; s < NSHARED; s++) begin
            sh_ok[s] = 1'b0;
            for (int p = 0; p < NPORTS; p++)
                if (cur_port == PW'(p) && sh_mask[s][p] && sh_valid[s] && sh_hit[s])
                    sh_ok[s] = 1'b1;
        end
        hit = own_hit | (|sh_ok);
    end

    sag_fsm #(.PW(PW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_active     (rx_active),
        .rx_port       (rx_port),
        .rx_byte_valid (rx_byte_valid),
        .rx_byte       (rx_byte),
        .secured       (secured),
        .learning      (learning),
        .hit           (hit),
        .cur_port      (cur_port),
        .sa_cmp        (sa_cmp),
        .learn_load    (learn_load),
        .scramble      (scramble)
    );

    sag_lfsr u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (scramble && bit_tick),
        .out_bit (lfsr_bit)
    );

    always_comb rand_bit = scramble & lfsr_bit;

    // R9: a frame is only ever blocked on a port that was secured at the decision
    p_block_needs_secure_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scramble) |-> $past(secured));
endmodule

// File: tb/sim_sag_guard.sv
module sim_sag_guard;
    localparam int NP = 4;
    localparam int NS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_active = 1'b0;
    logic [1:0] rx_port = '0;
    logic       rx_byte_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       bit_tick = 1'b0;
    logic       scramble, rand_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [12:0] lm = 13'd1;

    always #5 clk = ~clk;

    sag_guard #(.NPORTS(NP), .NSHARED(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_active(rx_active),
        .rx_port(rx_port), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
        .bit_tick(bit_tick), .scramble(scramble), .rand_bit(rand_bit)
    );

    function automatic logic [12:0] lstep(logic [12:0] s);
        return {s[11:0], s[12] ^ s[3] ^ s[2] ^ s[0]};
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string msg);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
        end
    endtask

    task automatic wr(input int kind, input int idx, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = {3'(kind), 2'(idx)};
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_check(input int kind, input int idx, input logic [7:0] exp, input string msg);
        @(negedge clk);
        reg_addr = {3'(kind), 2'(idx)};
        #1;
        check(reg_rdata, exp, msg);
    endtask

    task automatic load(input int kind, input int idx, input logic [47:0] a, input int nb);
        for (int b = 0; b < nb; b++) wr(kind, idx, a[b*8 +: 8]);
    endtask

    task automatic frame(input int p, input logic [47:0] sa, input logic exp_blk, input string tag);
        logic [47:0] da = 48'hFFFF_FFFF_FFFF;
        bit prev = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i == 11) check({7'b0, scramble}, 8'd0, {"R4 no decision before byte 12 ", tag});
            rx_active     = 1'b1;
            rx_port       = 2'(p);
            rx_byte_valid = 1'b1;
            rx_byte       = (i < 6) ? da[i*8 +: 8] : sa[(i-6)*8 +: 8];
        end
        @(negedge clk);
        rx_byte_valid = 1'b0;
        check({7'b0, scramble}, {7'b0, exp_blk}, {"R4 decision ", tag});
        for (int k = 0; k < 16; k++) begin
            if (k > 0) @(negedge clk);
            if (prev && exp_blk) lm = lstep(lm);
            check({7'b0, rand_bit}, {7'b0, exp_blk & lm[12]}, {"R11 substitute bit ", tag});
            bit_tick = 1'b1;
            prev = 1'b1;
        end
        @(negedge clk);
        if (prev && exp_blk) lm = lstep(lm);
        bit_tick = 1'b0;
        check({7'b0, scramble}, {7'b0, exp_blk}, {"R5 held to end ", tag});
        rx_active = 1'b0;
        @(negedge clk);
        check({7'b0, scramble}, 8'd0, {"R5 released ", tag});
        check({7'b0, rand_bit}, 8'd0, {"R11 quiet ", tag});
    endtask

    localparam logic [47:0] A0 = 48'h0A1B2C3D4E50;
    localparam logic [47:0] A1 = 48'h0A1B2C3D4E51;
    localparam logic [47:0] SX = 48'h66778899AABB;
    localparam logic [47:0] SY = 48'h1122334455C7;
    localparam logic [47:0] BAD = 48'hDEADBEEF0001;
    localparam logic [47:0] LRN = 48'h020406080A0C;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({7'b0, scramble}, 8'd0, "R1 scramble");
        check({7'b0, rand_bit}, 8'd0, "R1 rand_bit");
        for (int i = 0; i < 4; i++) begin
            rd_check(0, i, 8'h00, "R1 private loaded");
            rd_check(1, i, 8'h00, "R1 shared loaded");
            rd_check(2, i, 8'h00, "R1 mask");
            rd_check(3, i, 8'h00, "R1 valid");
            rd_check(6, i, 8'h00, "R1 port control");
        end
        rd_check(7, 0, 8'h00, "R1 global");

        // R2 byte-by-byte load
        load(0, 0, A0, 3);
        rd_check(0, 0, 8'h07, "R2 three bytes");
        wr(0, 0, A0[31:24]); wr(0, 0, A0[39:32]); wr(0, 0, A0[47:40]);
        rd_check(0, 0, 8'h3F, "R2 six bytes");

        // R12 reserved kinds have no effect
        wr(4, 0, 8'hFF); wr(5, 0, 8'hFF);
        rd_check(4, 0, 8'h00, "R12 kind4 reads 0");
        rd_check(0, 0, 8'h3F, "R12 kind4/5 write ignored");

        wr(7, 0, 8'h01);
        rd_check(7, 0, 8'h01, "R12 global readback");
        frame(0, A0, 1'b0, "R6 own private hit");
        frame(0, BAD, 1'b1, "R4 mismatch blocks");
        frame(1, A0, 1'b1, "R6 other port entry unused");

        // R7 partial entry
        load(0, 1, A1, 5);
        rd_check(0, 1, 8'h1F, "R2 five bytes");
        frame(1, A1, 1'b1, "R7 partial private");
        wr(0, 1, A1[47:40]);
        frame(1, A1, 1'b0, "R6 completed private");
        // R3 wrap
        wr(0, 1, A1[7:0]);
        rd_check(0, 1, 8'h01, "R3 wrap restart");
        frame(1, A1, 1'b1, "R7 after wrap");

        // R8 shared sweep: every mask against every port
        load(1, 0, SX, 6);
        rd_check(1, 0, 8'h3F, "R2 shared loaded");
        wr(3, 0, 8'h01);
        rd_check(3, 0, 8'h01, "R12 valid readback");
        for (int m = 0; m < 16; m++) begin
            wr(2, 0, 8'(m));
            rd_check(2, 0, 8'(m), "R12 mask readback");
            for (int p = 0; p < NP; p++)
                frame(p, SX, !m[p], "R8 mask sweep");
        end
        wr(2, 0, 8'h0F);
        wr(3, 0, 8'h00);
        frame(2, SX, 1'b1, "R8 invalid shared");
        // R7 partial shared marked valid
        load(1, 1, SY, 3);
        wr(3, 1, 8'h01); wr(2, 1, 8'h0F);
        frame(3, SY, 1'b1, "R7 partial valid shared");

        // R9 global and per-port enables
        wr(7, 0, 8'h00);
        frame(0, BAD, 1'b0, "R9 unsecured passes");
        wr(6, 2, 8'h01);
        rd_check(6, 2, 8'h01, "R12 port control readback");
        frame(2, BAD, 1'b1, "R9 per-port secured");
        frame(3, BAD, 1'b0, "R9 other port open");

        // R10 learn
        wr(6, 3, 8'h03);
        rd_check(6, 3, 8'h03, "R12 learn readback");
        frame(3, LRN, 1'b0, "R10 learning frame passes");
        rd_check(0, 3, 8'h3F, "R10 entry full after learn");
        wr(6, 3, 8'h01);
        frame(3, LRN, 1'b0, "R10 learned address matches");
        frame(3, BAD, 1'b1, "R10 other address blocks");
        frame(2, LRN, 1'b1, "R10 learned entry private to port");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule